// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a watchdog timer. Its counter can be restarted only by a two-step key sequence on an 8-bit key register. Software first writes 55h to arm the key logic. A later AAh write then restarts the counter. Any other byte written to the key register counts as a malfunction and requests a system reset at once.

The counter advances on an external clock-enable tick. When it overflows, it either requests a reset or raises an interrupt, as a mode bit selects. A control/status register holds:
- a clear-only override bit, which decides whether software may disable the watchdog;
- the mode bit;
- a read-only, active-low interrupt status flag;
- a disable request bit.

Register map, 2-bit address, 8-bit data:

| Address | Access | Content |
|---|---|---|
| 0 | write | Key register. Reads return 0. |
| 1 | read/write | Control/status: bit0 override, bit1 interrupt mode, bit2 interrupt status (active low, read-only), bit3 disable request, other bits read 0. |
| 2 | read | Counter value. |
| 3 | read | Bit0 is the armed state of the key logic. |

Register writes take effect at the clock edge where `wr_en_i` is high. Reads are combinational.

Top module: `kwdt_top`

## Requirements
- R1: After reset:
  - the counter is 0 and the key logic is unarmed;
  - override is 1, interrupt mode is 0, interrupt status reads 1 (inactive) and the disable request is 0;
  - `rst_req_o` and `irq_o` are low.
- R2: Writing 55h to address 0 sets the armed bit (address 3, bit0). Repeated 55h writes keep it set and leave the counter unchanged.
- R3: Writing AAh to address 0 while armed has three effects from the next cycle on:
  - the counter is 0;
  - the key logic is unarmed;
  - the interrupt status reads 1.
- R4: Writing AAh to address 0 while unarmed changes nothing.
- R5: Writing any other value to address 0 drives `rst_req_o` high for the next cycle, and clears the counter and the armed bit.
- R6: While the watchdog is enabled, the counter increments by one on each clock with `tick_i` high, and holds on clocks without a tick.
- R7: With interrupt mode 0, a tick at counter value FFh drives `rst_req_o` high for one cycle, and returns the counter and the armed bit to 0.
- R8: With interrupt mode 1, a tick at counter value FFh has these effects:
  - the status bit reads 0 and `irq_o` goes high;
  - the counter wraps to 0;
  - no reset is requested.
- R9: Writing 1 to control bit0 clears the override bit. Writing 0 leaves it unchanged. Once it is 0, no write sets it back to 1.
- R10: With override at 1 and disable request at 1, the counter holds on ticks. With override at 0, the disable request is ignored and the counter keeps running.
- R11: A write to control bit2 does not change the interrupt status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Counter clock enable |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | 2 | Read address |
| rd_data_o | output | 8 | Read data (combinational) |
| rst_req_o | output | 1 | One-cycle system reset request |
| irq_o | output | 1 | Watchdog interrupt, high while status is active |

## Verification
The bench aims at the key-sequence corner cases:
- An AAh write without a preceding 55h: a design that restarts on AAh alone would clear the counter.
- Back-to-back 55h writes: a design that toggles the armed state would lose the arm.
- A stray key byte: a design that fails here would miss the reset or leave the armed bit set.

Both overflow modes are driven through a full counter wrap:
- In interrupt mode, a design that also pulsed reset, or failed to wrap, would show up.
- The bench then tries to clear the status through the register, which must fail.

The override bit is checked against attempts to set it back to 1, and against a disable request issued after it has been cleared. A lock that leaks would freeze the counter.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
  localparam int unsigned DATA_W = 8;

  localparam logic [DATA_W-1:0] KEY_ARM  = 8'h55;
  localparam logic [DATA_W-1:0] KEY_KICK = 8'hAA;

  typedef enum logic [1:0] {
    ADDR_KEY  = 2'd0,
    ADDR_CTRL = 2'd1,
    ADDR_CNT  = 2'd2,
    ADDR_ARM  = 2'd3
  } addr_e;

  // Control register bit positions
  localparam int unsigned B_OVR  = 0;
  localparam int unsigned B_IEN  = 1;
  localparam int unsigned B_STAT = 2;
  localparam int unsigned B_DIS  = 3;
endpackage

// File: rtl/kwdt_key.sv
module kwdt_key
  import kwdt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              key_wr_i,
  input  logic [DATA_W-1:0] key_i,
  input  logic              clr_i,
  output logic              armed_o,
  output logic              restart_o,
  output logic              bad_o
);
  logic armed_q;
  logic is_arm, is_kick;

  assign is_arm    = key_i == KEY_ARM;
  assign is_kick   = key_i == KEY_KICK;
  assign restart_o = key_wr_i && is_kick && armed_q;
  assign bad_o     = key_wr_i && !is_arm && !is_kick;
  assign armed_o   = armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  armed_q <= 1'b0;
    else if (clr_i || restart_o)  armed_q <= 1'b0;
    else if (key_wr_i && is_arm)  armed_q <= 1'b1;
  end

  assert_arm_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (key_wr_i && is_arm && !clr_i) |=> armed_q);
  assert_unarmed_kick_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (key_wr_i && is_kick && !armed_q) |=> !armed_q);
endmodule

// File: rtl/kwdt_ctrl.sv
module kwdt_ctrl
  import kwdt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              restart_i,
  input  logic              to_irq_i,
  output logic              ovr_o,
  output logic              ien_o,
  output logic              dis_o,
  output logic              stat_n_o
);
  logic ovr_q, ien_q, dis_q, stat_n_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovr_q <= 1'b1;
      ien_q <= 1'b0;
      dis_q <= 1'b0;
    end else if (wr_i) begin
      ovr_q <= ovr_q & ~wdata_i[B_OVR];  // clear-only
      ien_q <= wdata_i[B_IEN];
      dis_q <= wdata_i[B_DIS];
    end
  end

  // Status is active low and has no write path
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        stat_n_q <= 1'b1;
    else if (restart_i) stat_n_q <= 1'b1;
    else if (to_irq_i)  stat_n_q <= 1'b0;
  end

  assign ovr_o    = ovr_q;
  assign ien_o    = ien_q;
  assign dis_o    = dis_q;
  assign stat_n_o = stat_n_q;

  assert_ovr_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ovr_q |=> !ovr_q);
  assert_stat_ro_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!restart_i && !to_irq_i) |=> $stable(stat_n_q));
endmodule

// File: rtl/kwdt_cnt.sv
module kwdt_cnt #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             restart_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             at_max_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (clr_i || restart_i) cnt_q <= '0;
    else if (inc_i)              cnt_q <= cnt_q + 1'b1;  // wraps at max
  end

  assign cnt_o    = cnt_q;
  assign at_max_o = cnt_q == CNT_MAX;

  assert_restart_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> cnt_q == '0);
  assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_i && !restart_i && !clr_i) |=> $stable(cnt_q));
endmodule

// File: rtl/kwdt_top.sv
module kwdt_top
  import kwdt_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [1:0]        rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rst_req_o,
  output logic              irq_o
);
  logic key_wr, ctrl_wr;
  logic armed, restart, bad;
  logic ovr, ien, dis, stat_n;
  logic wd_en, inc, at_max, tmo, to_rst, to_irq, clr;
  logic [CNT_W-1:0] cnt;
  logic rst_req_q;

  assign key_wr  = wr_en_i && (wr_addr_i == ADDR_KEY);
  assign ctrl_wr = wr_en_i && (wr_addr_i == ADDR_CTRL);

  assign wd_en  = !(ovr && dis);
  assign inc    = tick_i && wd_en;
  // A key event in the same cycle takes priority over overflow
  assign tmo    = inc && at_max && !restart && !bad;
  assign to_rst = tmo && !ien;
  assign to_irq = tmo && ien;
  assign clr    = bad || to_rst;

  kwdt_key u_key (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .key_wr_i  (key_wr),
    .key_i     (wr_data_i),
    .clr_i     (clr),
    .armed_o   (armed),
    .restart_o (restart),
    .bad_o     (bad)
  );

  kwdt_ctrl u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (ctrl_wr),
    .wdata_i   (wr_data_i),
    .restart_i (restart),
    .to_irq_i  (to_irq),
    .ovr_o     (ovr),
    .ien_o     (ien),
    .dis_o     (dis),
    .stat_n_o  (stat_n)
  );

  kwdt_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .inc_i     (inc),
    .restart_i (restart),
    .clr_i     (clr),
    .cnt_o     (cnt),
    .at_max_o  (at_max)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_req_q <= 1'b0;
    else         rst_req_q <= clr;
  end

  always_comb begin
    rd_data_o = '0;
    unique case (rd_addr_i)
      ADDR_CTRL: begin
        rd_data_o[B_OVR]  = ovr;
        rd_data_o[B_IEN]  = ien;
        rd_data_o[B_STAT] = stat_n;
        rd_data_o[B_DIS]  = dis;
      end
      ADDR_CNT: rd_data_o = DATA_W'(cnt);
      ADDR_ARM: rd_data_o[0] = armed;
      default:  rd_data_o = '0;
    endcase
  end

  assign rst_req_o = rst_req_q;
  assign irq_o     = !stat_n;

  assert_badkey_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad |=> (rst_req_o && !armed && cnt == '0));
  assert_to_rst_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    to_rst |=> (rst_req_o && cnt == '0 && !armed));
  assert_to_irq_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    to_irq |=> (irq_o && !rst_req_o && cnt == '0));
  assert_locked_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ovr && tick_i && !restart && !bad && !at_max) |=> cnt == $past(cnt) + 1'b1);
  assert_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr |=> !rst_req_o);
endmodule

// File: tb/sim_kwdt_top.sv
module sim_kwdt_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic [1:0] rd_addr = 2'd0;
  logic [7:0] rd_data;
  logic       rst_req, irq;

  int    n_chk = 0;
  int    n_fail = 0;
  string cur_req = "R1";

  // reference state
  int m_cnt = 0;
  bit m_armed = 0, m_ovr = 1, m_ien = 0, m_stat_n = 1, m_dis = 0, m_rst = 0;

  always #4 clk = ~clk;  // 125 MHz

  kwdt_top u0 (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .tick_i    (tick),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .rd_addr_i (rd_addr),
    .rd_data_o (rd_data),
    .rst_req_o (rst_req),
    .irq_o     (irq)
  );

  task automatic check(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic int exp_rd(logic [1:0] a);
    case (a)
      2'd1:    return {m_dis, m_stat_n, m_ien, m_ovr};
      2'd2:    return m_cnt;
      2'd3:    return int'(m_armed);
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_armed = 0; m_ovr = 1; m_ien = 0; m_stat_n = 1; m_dis = 0; m_rst = 0;
    end else begin
      bit bad, good, en, to, kick_rst;
      bad  = wr_en && wr_addr == 2'd0 && wr_data != 8'h55 && wr_data != 8'hAA;
      good = wr_en && wr_addr == 2'd0 && wr_data == 8'hAA && m_armed;
      en   = !(m_ovr && m_dis);
      to   = tick && en && m_cnt == 255 && !bad && !good;
      kick_rst = bad || (to && !m_ien);
      m_rst = kick_rst;
      if (kick_rst) begin
        m_cnt = 0; m_armed = 0;
      end else if (good) begin
        m_cnt = 0; m_armed = 0; m_stat_n = 1;
      end else begin
        if (wr_en && wr_addr == 2'd0 && wr_data == 8'h55) m_armed = 1;
        if (tick && en) m_cnt = (m_cnt + 1) % 256;
        if (to && m_ien) m_stat_n = 0;
      end
      if (wr_en && wr_addr == 2'd1) begin
        m_ovr = m_ovr & ~wr_data[0];
        m_ien = wr_data[1];
        m_dis = wr_data[3];
      end
    end
    #2;
    check(cur_req, "rst_req_o", int'(rst_req), int'(m_rst));
    check(cur_req, "irq_o", int'(irq), int'(!m_stat_n));
    check(cur_req, $sformatf("rd[%0d]", rd_addr), int'(rd_data), exp_rd(rd_addr));
  end

  always @(negedge clk) rd_addr <= rd_addr + 2'd1;

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick = 1'b1;
    end
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got hang expected completion");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    cur_req = "R1";
    idle(4);
    rst_n = 1'b1;
    idle(8);
    cur_req = "R6";  ticks(10); idle(4);
    cur_req = "R4";  wr(2'd0, 8'hAA); idle(4);
    cur_req = "R2";  wr(2'd0, 8'h55); wr(2'd0, 8'h55); ticks(3); idle(4);
    cur_req = "R3";  wr(2'd0, 8'hAA); idle(4);
    cur_req = "R5";  wr(2'd0, 8'h55); ticks(4); wr(2'd0, 8'h23); idle(4);
    cur_req = "R7";  wr(2'd0, 8'h55); ticks(260); idle(4);
    cur_req = "R8";  wr(2'd1, 8'h02); ticks(258); idle(4);
    cur_req = "R11"; wr(2'd1, 8'h06); idle(4); wr(2'd1, 8'h02); idle(4);
    cur_req = "R3";  wr(2'd0, 8'h55); wr(2'd0, 8'hAA); idle(4);
    cur_req = "R10"; wr(2'd1, 8'h0A); ticks(5); idle(4); wr(2'd1, 8'h02); ticks(2);
    cur_req = "R9";  wr(2'd1, 8'h0B); ticks(5); wr(2'd1, 8'h0A); idle(4); wr(2'd1, 8'h08);
    cur_req = "R10"; ticks(6); idle(4);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule